// File: doc/BRIEF.md
# First-Hit Address Selector

The block collects per-crossing hit reports from 32 front-end readout chips and forwards at most eight of them for each bunch crossing. Each chip drives one serial line. In the cycle where the crossing strobe is high, the line carries a hit flag. The six cycles after that carry the 6-bit strip address of that chip's earliest hit in the crossing, most significant bit first. A 6-bit address spans the 64 strips of one chip, and the address serves downstream as the hit coordinate.

When the next crossing strobe arrives, the block builds an output frame from the reports it has just received. The frame holds eight slots, and each slot carries a valid bit, the 5-bit index of the source line and the 6-bit strip address. The frame also carries a crossing ID. A round-robin pointer sets where the scan over the 32 lines begins, so when more than eight lines report, no line is starved. The pointer advances by one for every frame.

Top module: `first_hit_selector`

## Requirements
- R1: While rst_ni is low, frame_stb_o is 0 and frame_bcid_o, slot_vld_o, slot_src_o and slot_addr_o are all zero.
- R2: A line's flag is sampled in the cycle where bc_i is high. The following six cycles deliver address bits 5 down to 0. Line activity after the sixth address bit and before the next strobe has no effect on the frame.
- R3: On a clock edge where bc_i is sampled high and an earlier strobe has been seen since reset, the frame of the previous crossing is loaded, and frame_stb_o is high for the one following cycle. No frame follows the first strobe after reset. Between frames the outputs hold their values.
- R4: The first frame after reset carries crossing ID 0. Each later frame carries the previous ID plus one, modulo 2^12.
- R5: When at most eight lines flag a hit, every one of them appears in the frame, with its own source index and address.
- R6: When more than eight lines flag, exactly eight are forwarded: the first eight flagged lines met when scanning upward from the pointer, wrapping from line 31 to line 0. No source appears twice.
- R7: The pointer is 0 for the first frame after reset and increases by one (modulo 32) for each frame. Slot 0 holds the first flagged line at or above the pointer, and later slots follow the scan order.
- R8: Valid slots are packed from slot 0 upward. Every slot without a valid hit has source 0 and address 0.
- R9: The number of valid slots equals the smaller of eight and the number of flagged lines.
- R10: Consecutive crossing strobes are at least seven cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bc_i | input | 1 | Crossing strobe, one cycle per crossing |
| ser_i | input | 32 | Serial report lines, one per front-end chip |
| frame_stb_o | output | 1 | One-cycle pulse when a new frame is presented |
| frame_bcid_o | output | 12 | Crossing ID of the presented frame |
| slot_vld_o | output | 8 | Valid bit per slot |
| slot_src_o | output | 40 | Source line index per slot, 5 bits each, slot 0 in the low bits |
| slot_addr_o | output | 48 | Strip address per slot, 6 bits each, slot 0 in the low bits |

## Verification
The assertions check several properties on every cycle: the strobe-to-frame timing, that outputs stay stable between frames, that valid slots are packed and unused slots are zeroed, that no source repeats within a frame, that each crossing ID is one more than the last, and that strobes keep the minimum spacing. Only the bench scenarios can show the rest. This covers whether the chosen lines are the correct ones for a given pointer, whether the address bits arrive in the correct order, and whether trailing line activity is ignored. It also covers the crossing ID wrapping past 4095, since each of these needs a model of the stimulus.

// File: rtl/fhs_pkg.sv
package fhs_pkg;
  localparam int unsigned FHS_LANES  = 32;
  localparam int unsigned FHS_SLOTS  = 8;
  localparam int unsigned FHS_ADDR_W = 6;
  localparam int unsigned FHS_BCID_W = 12;

  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_e;
endpackage

// File: rtl/hit_lane_rx.sv
module hit_lane_rx
  import fhs_pkg::*;
#(
  parameter int unsigned ADDR_W = FHS_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bc_i,
  input  logic              ser_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned CNT_W = $clog2(ADDR_W + 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      hit_q   <= 1'b0;
      addr_q  <= '0;
    end else if (bc_i) begin
      // flag slot of the crossing; restarts the address shift
      state_q <= RX_SHIFT;
      cnt_q   <= '0;
      hit_q   <= ser_i;
      addr_q  <= '0;
    end else if (state_q == RX_SHIFT) begin
      addr_q <= {addr_q[ADDR_W-2:0], ser_i};
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(ADDR_W - 1)) state_q <= RX_IDLE;
    end
  end

  assign hit_o  = hit_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/hit_rr_pick.sv
module hit_rr_pick
  import fhs_pkg::*;
#(
  parameter int unsigned N_LANE = FHS_LANES,
  parameter int unsigned N_SLOT = FHS_SLOTS,
  parameter int unsigned ADDR_W = FHS_ADDR_W,
  parameter int unsigned IDX_W  = $clog2(FHS_LANES)
) (
  input  logic [N_LANE-1:0]        hit_i,
  input  logic [N_LANE*ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]         ptr_i,
  output logic [N_SLOT-1:0]        vld_o,
  output logic [N_SLOT*IDX_W-1:0]  src_o,
  output logic [N_SLOT*ADDR_W-1:0] addr_o
);
  // scan from the pointer, wrap, fill slots in scan order
  always_comb begin
    int unsigned n;
    int unsigned lane;
    vld_o  = '0;
    src_o  = '0;
    addr_o = '0;
    n      = 0;
    for (int unsigned j = 0; j < N_LANE; j++) begin
      lane = (int'(ptr_i) + j) % N_LANE;
      if (hit_i[lane] && n < N_SLOT) begin
        vld_o[n]                 = 1'b1;
        src_o[n*IDX_W +: IDX_W]  = IDX_W'(lane);
        addr_o[n*ADDR_W +: ADDR_W] = addr_i[lane*ADDR_W +: ADDR_W];
        n = n + 1;
      end
    end
  end
endmodule

// File: rtl/fhs_framer.sv
module fhs_framer
  import fhs_pkg::*;
#(
  parameter int unsigned N_LANE = FHS_LANES,
  parameter int unsigned N_SLOT = FHS_SLOTS,
  parameter int unsigned ADDR_W = FHS_ADDR_W,
  parameter int unsigned BCID_W = FHS_BCID_W,
  parameter int unsigned IDX_W  = $clog2(FHS_LANES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bc_i,
  input  logic [N_SLOT-1:0]        pick_vld_i,
  input  logic [N_SLOT*IDX_W-1:0]  pick_src_i,
  input  logic [N_SLOT*ADDR_W-1:0] pick_addr_i,
  output logic [IDX_W-1:0]         ptr_o,
  output logic                     stb_o,
  output logic [BCID_W-1:0]        bcid_o,
  output logic [N_SLOT-1:0]        vld_o,
  output logic [N_SLOT*IDX_W-1:0]  src_o,
  output logic [N_SLOT*ADDR_W-1:0] addr_o
);
  logic              seen_q;
  logic [BCID_W-1:0] cnt_q;
  logic [IDX_W-1:0]  ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      stb_o  <= 1'b0;
      bcid_o <= '0;
      vld_o  <= '0;
      src_o  <= '0;
      addr_o <= '0;
    end else begin
      stb_o <= 1'b0;
      if (bc_i) begin
        seen_q <= 1'b1;
        // first strobe only opens crossing 0
        if (seen_q) begin
          stb_o  <= 1'b1;
          bcid_o <= cnt_q;
          vld_o  <= pick_vld_i;
          src_o  <= pick_src_i;
          addr_o <= pick_addr_i;
          cnt_q  <= cnt_q + 1'b1;
          ptr_q  <= (ptr_q == IDX_W'(N_LANE - 1)) ? '0 : ptr_q + 1'b1;
        end
      end
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/first_hit_selector.sv
module first_hit_selector
  import fhs_pkg::*;
#(
  parameter int unsigned N_LANE = FHS_LANES,
  parameter int unsigned N_SLOT = FHS_SLOTS,
  parameter int unsigned ADDR_W = FHS_ADDR_W,
  parameter int unsigned BCID_W = FHS_BCID_W,
  localparam int unsigned IDX_W = $clog2(N_LANE)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bc_i,
  input  logic [N_LANE-1:0]        ser_i,
  output logic                     frame_stb_o,
  output logic [BCID_W-1:0]        frame_bcid_o,
  output logic [N_SLOT-1:0]        slot_vld_o,
  output logic [N_SLOT*IDX_W-1:0]  slot_src_o,
  output logic [N_SLOT*ADDR_W-1:0] slot_addr_o
);
  logic [N_LANE-1:0]        lane_hit;
  logic [N_LANE*ADDR_W-1:0] lane_addr;
  logic [IDX_W-1:0]         rr_ptr;
  logic [N_SLOT-1:0]        pick_vld;
  logic [N_SLOT*IDX_W-1:0]  pick_src;
  logic [N_SLOT*ADDR_W-1:0] pick_addr;

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    hit_lane_rx #(.ADDR_W(ADDR_W)) u_rx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bc_i   (bc_i),
      .ser_i  (ser_i[l]),
      .hit_o  (lane_hit[l]),
      .addr_o (lane_addr[l*ADDR_W +: ADDR_W])
    );
  end

  hit_rr_pick #(
    .N_LANE (N_LANE),
    .N_SLOT (N_SLOT),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_pick (
    .hit_i  (lane_hit),
    .addr_i (lane_addr),
    .ptr_i  (rr_ptr),
    .vld_o  (pick_vld),
    .src_o  (pick_src),
    .addr_o (pick_addr)
  );

  fhs_framer #(
    .N_LANE (N_LANE),
    .N_SLOT (N_SLOT),
    .ADDR_W (ADDR_W),
    .BCID_W (BCID_W),
    .IDX_W  (IDX_W)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bc_i        (bc_i),
    .pick_vld_i  (pick_vld),
    .pick_src_i  (pick_src),
    .pick_addr_i (pick_addr),
    .ptr_o       (rr_ptr),
    .stb_o       (frame_stb_o),
    .bcid_o      (frame_bcid_o),
    .vld_o       (slot_vld_o),
    .src_o       (slot_src_o),
    .addr_o      (slot_addr_o)
  );
endmodule

// File: rtl/fhs_chk.sv
module fhs_chk #(
  parameter int unsigned N_SLOT = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BCID_W = 12,
  parameter int unsigned IDX_W  = 5
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     bc_i,
  input logic                     frame_stb_o,
  input logic [BCID_W-1:0]        frame_bcid_o,
  input logic [N_SLOT-1:0]        slot_vld_o,
  input logic [N_SLOT*IDX_W-1:0]  slot_src_o,
  input logic [N_SLOT*ADDR_W-1:0] slot_addr_o
);
  localparam int unsigned GAP_W = $clog2(ADDR_W + 3) + 1;

  logic              have_prev_q;
  logic [BCID_W-1:0] prev_bcid_q;
  logic              bc_seen_q;
  logic [GAP_W-1:0]  gap_q;
  logic              dup;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      prev_bcid_q <= '0;
      bc_seen_q   <= 1'b0;
      gap_q       <= '0;
    end else begin
      if (frame_stb_o) begin
        have_prev_q <= 1'b1;
        prev_bcid_q <= frame_bcid_o;
      end
      if (bc_i) begin
        bc_seen_q <= 1'b1;
        gap_q     <= GAP_W'(1);
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < N_SLOT; a++)
      for (int b = a + 1; b < N_SLOT; b++)
        if (slot_vld_o[a] && slot_vld_o[b] &&
            slot_src_o[a*IDX_W +: IDX_W] == slot_src_o[b*IDX_W +: IDX_W])
          dup = 1'b1;
  end

  a_r3_stb_after_bc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> $past(bc_i));

  a_r3_frame_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_o |-> ($stable(slot_vld_o) && $stable(slot_src_o) &&
                      $stable(slot_addr_o) && $stable(frame_bcid_o)));

  a_r4_bcid_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_o && have_prev_q) |-> frame_bcid_o == prev_bcid_q + 1'b1);

  a_r6_src_unique: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> !dup);

  a_r8_vld_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_o & (slot_vld_o + N_SLOT'(1))) == '0);

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    a_r8_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_vld_o[s] |-> (slot_src_o[s*IDX_W +: IDX_W] == '0 &&
                          slot_addr_o[s*ADDR_W +: ADDR_W] == '0));
  end

  a_r10_bc_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_i && bc_seen_q) |-> gap_q >= GAP_W'(ADDR_W + 1));
endmodule

bind first_hit_selector fhs_chk #(
  .N_SLOT (N_SLOT),
  .ADDR_W (ADDR_W),
  .BCID_W (BCID_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bc_i         (bc_i),
  .frame_stb_o  (frame_stb_o),
  .frame_bcid_o (frame_bcid_o),
  .slot_vld_o   (slot_vld_o),
  .slot_src_o   (slot_src_o),
  .slot_addr_o  (slot_addr_o)
);

// File: tb/first_hit_selector_test.sv
`timescale 1ns/1ps
module first_hit_selector_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bc_i = 1'b0;
  logic [31:0] ser_i = '0;
  logic        frame_stb_o;
  logic [11:0] frame_bcid_o;
  logic [7:0]  slot_vld_o;
  logic [39:0] slot_src_o;
  logic [47:0] slot_addr_o;

  first_hit_selector uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bc_i(bc_i), .ser_i(ser_i),
    .frame_stb_o(frame_stb_o), .frame_bcid_o(frame_bcid_o),
    .slot_vld_o(slot_vld_o), .slot_src_o(slot_src_o), .slot_addr_o(slot_addr_o)
  );

  always #5 clk_i = ~clk_i;

  int total = 0;
  int bad = 0;
  logic [5:0]  cur_addr [32];
  logic [5:0]  prev_addr [32];
  logic [31:0] prev_flags;
  string       prev_tag;
  bit          pending = 0;
  int          cross_n = 0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic check_prev();
    logic [7:0]  ev = '0;
    logic [39:0] es = '0;
    logic [47:0] ea = '0;
    int ptr = (cross_n - 1) % 32;
    int n = 0;
    int cnt = 0;
    for (int j = 0; j < 32; j++) begin
      int lane = (ptr + j) % 32;
      if (prev_flags[lane]) begin
        cnt++;
        if (n < 8) begin
          ev[n] = 1'b1;
          es[n*5 +: 5] = 5'(lane);
          ea[n*6 +: 6] = prev_addr[lane];
          n++;
        end
      end
    end
    chk(frame_stb_o == 1'b1, "R3", "frame strobe", 64'(frame_stb_o), 64'd1);
    chk(frame_bcid_o == 12'((cross_n - 1) % 4096), "R4", "crossing id",
        64'(frame_bcid_o), 64'((cross_n - 1) % 4096));
    chk($countones(slot_vld_o) == ((cnt < 8) ? cnt : 8), "R9", "valid count",
        64'($countones(slot_vld_o)), 64'((cnt < 8) ? cnt : 8));
    chk(slot_vld_o == ev, prev_tag, "valid bits", 64'(slot_vld_o), 64'(ev));
    chk(slot_src_o == es, prev_tag, "sources", 64'(slot_src_o), 64'(es));
    chk(slot_addr_o == ea, prev_tag, "addresses", 64'(slot_addr_o), 64'(ea));
    for (int s = n; s < 8; s++)
      chk(slot_src_o[s*5 +: 5] == '0 && slot_addr_o[s*6 +: 6] == '0, "R8",
          "unused slot zero", 64'({slot_src_o[s*5 +: 5], slot_addr_o[s*6 +: 6]}), 64'd0);
  endtask

  // one crossing: flag cycle, six address cycles, one noise cycle
  task automatic send_crossing(input logic [31:0] flags, input string tag);
    @(negedge clk_i);
    bc_i  = 1'b1;
    ser_i = flags;
    @(negedge clk_i);
    if (pending) check_prev();
    else chk(frame_stb_o == 1'b0, "R3", "no frame after first strobe",
             64'(frame_stb_o), 64'd0);
    bc_i = 1'b0;
    for (int b = 5; b >= 0; b--) begin
      if (b != 5) @(negedge clk_i);
      if (b == 2) chk(frame_stb_o == 1'b0, "R3", "strobe low mid-crossing",
                      64'(frame_stb_o), 64'd0);
      for (int l = 0; l < 32; l++) ser_i[l] = cur_addr[l][b];
    end
    @(negedge clk_i);
    ser_i = '1;  // trailing activity, must be ignored (R2)
    prev_flags = flags;
    prev_tag   = tag;
    for (int l = 0; l < 32; l++) prev_addr[l] = cur_addr[l];
    pending = 1;
    cross_n++;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(frame_stb_o == 0 && frame_bcid_o == 0 && slot_vld_o == 0 &&
        slot_src_o == 0 && slot_addr_o == 0, "R1", "reset outputs",
        64'({frame_stb_o, slot_vld_o, frame_bcid_o}), 64'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_few();
    for (int l = 0; l < 32; l++) cur_addr[l] = 6'(l * 7 + 3);
    send_crossing(32'h0, "R5");
    send_crossing((32'h1 << 2) | (32'h1 << 17) | (32'h1 << 30), "R5");
  endtask

  task automatic t_none();
    send_crossing(32'h0, "R8");
  endtask

  task automatic t_msb();
    for (int l = 0; l < 32; l++) cur_addr[l] = (l % 2 == 0) ? 6'b100000 : 6'b000001;
    send_crossing(32'h0000_0F00, "R2");
    for (int l = 0; l < 32; l++) cur_addr[l] = 6'(63 - l);
  endtask

  task automatic t_exact8();
    send_crossing(32'h8181_8181, "R9");
  endtask

  task automatic t_many();
    send_crossing(32'hFFFF_FFFF, "R6");
    send_crossing(32'hFFFF_FFFF, "R6");
    send_crossing(32'h0000_03FF, "R6");
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 34; k++)
      send_crossing(32'h8000_0003 | (32'h1 << (k % 32)), "R7");
  endtask

  task automatic t_long();
    for (int k = 0; k < 4100; k++) begin
      rng = next_rng(rng);
      for (int l = 0; l < 32; l++) cur_addr[l] = 6'(rng >> (l % 26)) ^ 6'(l);
      rng = next_rng(rng);
      send_crossing((k % 3 == 0) ? rng : (rng & next_rng(rng)), "R4");
    end
  endtask

  initial begin
    #1_800_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int l = 0; l < 32; l++) cur_addr[l] = '0;
    t_reset();
    t_few();
    t_none();
    t_msb();
    t_exact8();
    t_many();
    t_wrap();
    t_long();
    send_crossing(32'h0, "R8");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule